// File: doc/BRIEF.md
# Serial Debug Command Decoder

This block sits behind the shift register of a serial debug port. It takes one 16-bit command word at a time, together with an address and a data operand. It sorts the word into a register access, a memory access, an execution control action or an unknown opcode, and it drives the matching port. For each command it sends back exactly one response, made of a 2-bit status tag and a 32-bit data word.

The processor core, the bus and the register files stay outside the block. They are reached through plain request ports:

- Memory: a request/acknowledge port that accepts byte, word and longword transfers.
- Registers: a combinational access port that covers the core registers, the system control registers and the debug unit registers.
- Control: a one-cycle restart strobe and a one-cycle program-counter capture strobe.

A halted-status input decides whether the commands that need a stopped core may run. Block transfers follow a simple rule. A memory read or write opens a block. Each following continuation command moves on from the last address, stepping by the byte count of the previous transfer.

Top module: `serial_dbg_cmd_decoder`

## Requirements
- R1: During and right after reset, `rsp_valid`, `mem_req`, `reg_en`, `cpu_restart` and `pc_capture` are 0 and `cmd_ready` is 1.
- R2: Opcodes 0x218X (read) and 0x208X (write) access core register X, where bit 3 selects address (1) or data (0) and bits 2:0 give the number. During the accept cycle they drive `reg_en`=1, `reg_space`=0 and `reg_idx`=X. The response comes one cycle after accept, with tag 00 and the read value, or 0 for a write.
- R3: Core register, control register and restart commands issued while `cpu_halted`=0 return tag 01 (not ready) with data 0. They raise no `reg_en` and no `cpu_restart`.
- R4: Opcodes 0x19S0 (read) and 0x18S0 (write) run in any CPU state. S is bits 7:6: 00 byte, 01 word, 10 longword. They issue one `mem_req` at `cmd_addr` with `mem_size`=S. Write data and read results are zero-extended from the low S-sized part. The response (tag 00) comes one cycle after the `mem_ack` cycle.
- R5: Opcodes 0x1DS0 (read continuation) and 0x1CS0 (write continuation) access the previous transfer address plus 1, 2 or 4 (the previous size), using their own size S. They are legal only while the last memory transfer since reset or restart was a read (for 0x1D) or a write (for 0x1C). Otherwise they return tag 11 and start no bus cycle.
- R6: Opcode 0x0C00, while halted, pulses `cpu_restart` for one cycle together with a tag-00 response. It also closes any open block.
- R7: Opcode 0x0000 returns tag 00 with data 0. Opcode 0x0001 returns the same and pulses `pc_capture` for one cycle. Both work in any CPU state.
- R8: Opcodes 0x2980 (read) and 0x2880 (write) access control register `cmd_addr[CTRL_IDX_W-1:0]` with `reg_space`=1. They work only while halted.
- R9: Opcodes 0x2D followed by bits 7:5 = 100 (read), or 0x2C followed by 100 (write), access debug register bits 4:0 with `reg_space`=2. They work in any CPU state.
- R10: Any other opcode returns tag 11 with data 0 and has no side effect. This includes a size field of 11 and a debug opcode whose bits 7:5 differ from 100.
- R11: A word access at an odd address, or a longword access at an address not divisible by 4, returns tag 10 and starts no bus cycle. A transfer acknowledged with `mem_err`=1 returns tag 10 with data 0.
- R12: While `mem_req` is high, `cmd_ready` is 0. `mem_req`, `mem_addr` and `mem_size` stay unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 16 | Command word |
| cmd_addr | input | ADDR_W | Address operand |
| cmd_data | input | DATA_W | Data operand |
| cpu_halted | input | 1 | Core is stopped |
| rsp_valid | output | 1 | Response pulse |
| rsp_tag | output | 2 | 00 ok, 01 not ready, 10 error, 11 illegal |
| rsp_data | output | DATA_W | Response data |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Write access |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 2 | 00 byte, 01 word, 10 longword |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Bus access done |
| mem_rdata | input | DATA_W | Read data |
| mem_err | input | 1 | Bus fault with ack |
| reg_en | output | 1 | Register access strobe |
| reg_we | output | 1 | Register write |
| reg_space | output | 2 | 0 core, 1 control, 2 debug |
| reg_idx | output | CTRL_IDX_W | Register index |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Register read data, combinational |
| cpu_restart | output | 1 | Flush and resume strobe |
| pc_capture | output | 1 | PC capture strobe |

## Verification
Results arrive at different times:

- The register port is combinational during the accept cycle, so the bench samples it 1 ns after it drives the command.
- The response, the restart strobe and the capture strobe are registered at the accept edge, so the bench expects them at the falling edge one cycle later.
- A memory command first shows `mem_req` one cycle after accept. The bench acknowledges it in that same cycle and expects the response at the next falling edge, two cycles after accept.

The bench counts cycles until `rsp_valid` and compares that count with the expected latency of each command class. It also tracks the open block in its own model, so continuation addresses are predicted across random sequences.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;

   typedef enum logic [1:0] {
      TAG_OK   = 2'b00,
      TAG_NRDY = 2'b01,
      TAG_ERR  = 2'b10,
      TAG_ILL  = 2'b11
   } rsp_tag_e;

   typedef enum logic [1:0] {
      SP_CORE = 2'd0,
      SP_CTRL = 2'd1,
      SP_DBG  = 2'd2
   } reg_space_e;

   typedef enum logic [3:0] {
      OP_NOP, OP_SYNC, OP_GO,
      OP_RREG, OP_WREG,
      OP_RMEM, OP_WMEM, OP_DUMP, OP_FILL,
      OP_RCTL, OP_WCTL, OP_RDBG, OP_WDBG,
      OP_BAD
   } op_kind_e;

   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         2'b00:   size_bytes = 3'd1;
         2'b01:   size_bytes = 3'd2;
         2'b10:   size_bytes = 3'd4;
         default: size_bytes = 3'd0;
      endcase
   endfunction

   function automatic logic [31:0] fit_to_size(input logic [31:0] d, input logic [1:0] sz);
      case (sz)
         2'b00:   fit_to_size = {24'd0, d[7:0]};
         2'b01:   fit_to_size = {16'd0, d[15:0]};
         default: fit_to_size = d;
      endcase
   endfunction

endpackage

// File: rtl/sdbg_opdecode.sv
module sdbg_opdecode
   import sdbg_pkg::*;
(
   input  logic [15:0] op,
   output op_kind_e    kind,
   output logic        halt_only,
   output logic [1:0]  sz,
   output logic [4:0]  idx
);

   always_comb begin
      kind = OP_BAD;
      sz   = op[7:6];
      idx  = 5'd0;
      if (op == 16'h0000)
         kind = OP_NOP;
      else if (op == 16'h0001)
         kind = OP_SYNC;
      else if (op == 16'h0C00)
         kind = OP_GO;
      else if (op[15:4] == 12'h218) begin
         kind = OP_RREG;
         idx  = {1'b0, op[3:0]};
      end else if (op[15:4] == 12'h208) begin
         kind = OP_WREG;
         idx  = {1'b0, op[3:0]};
      end else if (op == 16'h2980)
         kind = OP_RCTL;
      else if (op == 16'h2880)
         kind = OP_WCTL;
      else if (op[15:8] == 8'h2D && op[7:5] == 3'b100) begin
         kind = OP_RDBG;
         idx  = op[4:0];
      end else if (op[15:8] == 8'h2C && op[7:5] == 3'b100) begin
         kind = OP_WDBG;
         idx  = op[4:0];
      end else if (op[5:0] == 6'd0 && op[7:6] != 2'b11) begin
         case (op[15:8])
            8'h19:   kind = OP_RMEM;
            8'h18:   kind = OP_WMEM;
            8'h1D:   kind = OP_DUMP;
            8'h1C:   kind = OP_FILL;
            default: kind = OP_BAD;
         endcase
      end
      halt_only = (kind == OP_GO)   || (kind == OP_RREG) || (kind == OP_WREG) ||
                  (kind == OP_RCTL) || (kind == OP_WCTL);
   end

endmodule

// File: rtl/sdbg_blkptr.sv
module sdbg_blkptr
   import sdbg_pkg::*;
#(
   parameter int ADDR_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic              upd_rd,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [1:0]        upd_sz,
   input  logic              clr,
   output logic [ADDR_W-1:0] next_addr,
   output logic              setup_rd,
   output logic              setup_wr
);

   logic [ADDR_W-1:0] blk_addr;
   logic [1:0]        blk_sz;

   assign next_addr = blk_addr + ADDR_W'(size_bytes(blk_sz));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_addr <= '0;
         blk_sz   <= 2'b00;
         setup_rd <= 1'b0;
         setup_wr <= 1'b0;
      end else if (clr) begin
         setup_rd <= 1'b0;
         setup_wr <= 1'b0;
      end else if (upd) begin
         blk_addr <= upd_addr;
         blk_sz   <= upd_sz;
         setup_rd <= upd_rd;
         setup_wr <= !upd_rd;
      end
   end

   AST_CHAIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(setup_rd && setup_wr)); // R5

   AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      upd && !clr |=> blk_addr == $past(upd_addr)); // R5

endmodule

// File: rtl/sdbg_memseq.sv
module sdbg_memseq
   import sdbg_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_we,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [1:0]        start_sz,
   input  logic [DATA_W-1:0] start_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_err,
   output logic              done,
   output logic [DATA_W-1:0] done_data,
   output logic              done_err
);

   assign done      = mem_req && mem_ack;
   assign done_err  = mem_err;
   assign done_data = mem_we ? '0 : fit_to_size(mem_rdata, mem_size);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_size  <= 2'b00;
         mem_wdata <= '0;
      end else if (start) begin
         mem_req   <= 1'b1;
         mem_we    <= start_we;
         mem_addr  <= start_addr;
         mem_size  <= start_sz;
         mem_wdata <= start_we ? fit_to_size(start_wdata, start_sz) : '0;
      end else if (done) begin
         mem_req   <= 1'b0;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_size)); // R12

   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !mem_req); // R12

   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !mem_req); // R4

endmodule

// File: rtl/serial_dbg_cmd_decoder.sv
module serial_dbg_cmd_decoder
   import sdbg_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int CTRL_IDX_W  = 12,
   parameter bit ALIGN_CHECK = 1'b1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   output logic                  cmd_ready,
   input  logic [15:0]           cmd_op,
   input  logic [ADDR_W-1:0]     cmd_addr,
   input  logic [DATA_W-1:0]     cmd_data,
   input  logic                  cpu_halted,
   output logic                  rsp_valid,
   output logic [1:0]            rsp_tag,
   output logic [DATA_W-1:0]     rsp_data,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [1:0]            mem_size,
   output logic [DATA_W-1:0]     mem_wdata,
   input  logic                  mem_ack,
   input  logic [DATA_W-1:0]     mem_rdata,
   input  logic                  mem_err,
   output logic                  reg_en,
   output logic                  reg_we,
   output logic [1:0]            reg_space,
   output logic [CTRL_IDX_W-1:0] reg_idx,
   output logic [DATA_W-1:0]     reg_wdata,
   input  logic [DATA_W-1:0]     reg_rdata,
   output logic                  cpu_restart,
   output logic                  pc_capture
);

   localparam int DBG_IDX_W = 5;

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("DATA_W must be 32");
      end
      if (CTRL_IDX_W < DBG_IDX_W || CTRL_IDX_W > ADDR_W) begin : g_bad_idx_w
         $error("CTRL_IDX_W must lie between 5 and ADDR_W");
      end
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("ADDR_W too small");
      end
   endgenerate

   op_kind_e          kind;
   logic              halt_only;
   logic [1:0]        op_sz;
   logic [4:0]        op_idx;

   logic              accept;
   logic              is_mem, is_chain, rd_dir, chain_ok, aligned;
   logic [ADDR_W-1:0] eff_addr;
   logic [ADDR_W-1:0] next_addr;
   logic              setup_rd, setup_wr;

   rsp_tag_e          imm_tag;
   logic [DATA_W-1:0] imm_data;
   logic              mem_go, reg_go, go_fire, sync_fire;

   logic              mem_done, mem_done_err;
   logic [DATA_W-1:0] mem_done_data;

   sdbg_opdecode u_dec (
      .op        (cmd_op),
      .kind      (kind),
      .halt_only (halt_only),
      .sz        (op_sz),
      .idx       (op_idx)
   );

   assign cmd_ready = !mem_req;
   assign accept    = cmd_valid && cmd_ready;

   assign is_chain = (kind == OP_DUMP) || (kind == OP_FILL);
   assign is_mem   = is_chain || (kind == OP_RMEM) || (kind == OP_WMEM);
   assign rd_dir   = (kind == OP_RMEM) || (kind == OP_DUMP);
   assign eff_addr = is_chain ? next_addr : cmd_addr;
   assign chain_ok = (kind == OP_DUMP) ? setup_rd :
                     (kind == OP_FILL) ? setup_wr : 1'b1;

   generate
      if (ALIGN_CHECK) begin : g_align
         assign aligned = (op_sz == 2'b00) ||
                          (op_sz == 2'b01 && !eff_addr[0]) ||
                          (op_sz == 2'b10 && eff_addr[1:0] == 2'b00);
      end else begin : g_noalign
         assign aligned = 1'b1;
      end
   endgenerate

   always_comb begin
      imm_tag   = TAG_OK;
      imm_data  = '0;
      mem_go    = 1'b0;
      reg_go    = 1'b0;
      go_fire   = 1'b0;
      sync_fire = 1'b0;
      if (kind == OP_BAD)
         imm_tag = TAG_ILL;
      else if (halt_only && !cpu_halted)
         imm_tag = TAG_NRDY;
      else if (is_mem) begin
         if (!chain_ok)
            imm_tag = TAG_ILL;
         else if (!aligned)
            imm_tag = TAG_ERR;
         else
            mem_go = 1'b1;
      end else begin
         case (kind)
            OP_GO:   go_fire   = 1'b1;
            OP_SYNC: sync_fire = 1'b1;
            OP_RREG, OP_RCTL, OP_RDBG: begin
               reg_go   = 1'b1;
               imm_data = reg_rdata;
            end
            OP_WREG, OP_WCTL, OP_WDBG:
               reg_go = 1'b1;
            default: ;
         endcase
      end
   end

   // Register port, combinational during the accept cycle
   assign reg_en    = accept && reg_go;
   assign reg_we    = (kind == OP_WREG) || (kind == OP_WCTL) || (kind == OP_WDBG);
   assign reg_wdata = cmd_data;

   always_comb begin
      reg_space = SP_DBG;
      reg_idx   = CTRL_IDX_W'(op_idx);
      if (kind == OP_RREG || kind == OP_WREG)
         reg_space = SP_CORE;
      else if (kind == OP_RCTL || kind == OP_WCTL) begin
         reg_space = SP_CTRL;
         reg_idx   = cmd_addr[CTRL_IDX_W-1:0];
      end
   end

   sdbg_blkptr #(.ADDR_W(ADDR_W)) u_blk (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (accept && mem_go),
      .upd_rd    (rd_dir),
      .upd_addr  (eff_addr),
      .upd_sz    (op_sz),
      .clr       (accept && go_fire),
      .next_addr (next_addr),
      .setup_rd  (setup_rd),
      .setup_wr  (setup_wr)
   );

   sdbg_memseq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept && mem_go),
      .start_we    (!rd_dir),
      .start_addr  (eff_addr),
      .start_sz    (op_sz),
      .start_wdata (cmd_data),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_size    (mem_size),
      .mem_wdata   (mem_wdata),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata),
      .mem_err     (mem_err),
      .done        (mem_done),
      .done_data   (mem_done_data),
      .done_err    (mem_done_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_tag     <= TAG_OK;
         rsp_data    <= '0;
         cpu_restart <= 1'b0;
         pc_capture  <= 1'b0;
      end else begin
         rsp_valid   <= (accept && !mem_go) || mem_done;
         cpu_restart <= accept && go_fire;
         pc_capture  <= accept && sync_fire;
         if (mem_done) begin
            rsp_tag  <= mem_done_err ? TAG_ERR : TAG_OK;
            rsp_data <= mem_done_err ? '0 : mem_done_data;
         end else if (accept) begin
            rsp_tag  <= imm_tag;
            rsp_data <= imm_data;
         end
      end
   end

   AST_HALT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      reg_en && reg_space != SP_DBG |-> cpu_halted); // R3

   AST_RESTART_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_restart |-> $past(cpu_halted)); // R6

   AST_ILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_tag == TAG_ILL |-> rsp_data == '0); // R10

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cmd_ready); // R12

   generate
      if (ALIGN_CHECK) begin : g_align_chk
         AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req |-> (mem_size == 2'b00) ||
                        (mem_size == 2'b01 && !mem_addr[0]) ||
                        (mem_size == 2'b10 && mem_addr[1:0] == 2'b00)); // R11
      end
   endgenerate

endmodule

// File: tb/test_serial_dbg_cmd_decoder.sv
`timescale 1ns/1ps
module test_serial_dbg_cmd_decoder;

   localparam int K_NOP = 0, K_SYNC = 1, K_GO = 2, K_RREG = 3, K_WREG = 4,
                  K_RMEM = 5, K_WMEM = 6, K_DUMP = 7, K_FILL = 8, K_RCTL = 9,
                  K_WCTL = 10, K_RDBG = 11, K_WDBG = 12, K_BAD = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [15:0] cmd_op = '0;
   logic [31:0] cmd_addr = '0;
   logic [31:0] cmd_data = '0;
   logic        cpu_halted = 1'b0;
   logic        rsp_valid;
   logic [1:0]  rsp_tag;
   logic [31:0] rsp_data;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [1:0]  mem_size;
   logic        mem_ack = 1'b0;
   logic        err_inj = 1'b0;
   logic        reg_en, reg_we;
   logic [1:0]  reg_space;
   logic [11:0] reg_idx;
   logic [31:0] reg_wdata, reg_rdata;
   logic        cpu_restart, pc_capture;

   int n_chk = 0;
   int n_fail = 0;

   bit          m_rd = 0, m_wr = 0;
   logic [31:0] m_addr = '0;
   logic [1:0]  m_sz = '0;

   always #2.5 clk = ~clk;

   function automatic logic [31:0] memval(input logic [31:0] a);
      return {a[15:0] ^ 16'h3C96, a[15:0]};
   endfunction

   function automatic logic [31:0] regval(input logic [1:0] s, input logic [11:0] i);
      return {8'h5A, 2'b00, s, 8'h00, i};
   endfunction

   function automatic logic [31:0] fit(input logic [31:0] d, input logic [1:0] sz);
      if (sz == 2'b00) return {24'd0, d[7:0]};
      if (sz == 2'b01) return {16'd0, d[15:0]};
      return d;
   endfunction

   function automatic logic [31:0] nbytes(input logic [1:0] sz);
      return (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
   endfunction

   function automatic int bkind(input logic [15:0] op);
      if (op == 16'h0000) return K_NOP;
      if (op == 16'h0001) return K_SYNC;
      if (op == 16'h0C00) return K_GO;
      if (op[15:4] == 12'h218) return K_RREG;
      if (op[15:4] == 12'h208) return K_WREG;
      if (op == 16'h2980) return K_RCTL;
      if (op == 16'h2880) return K_WCTL;
      if (op[15:5] == {8'h2D, 3'b100}) return K_RDBG;
      if (op[15:5] == {8'h2C, 3'b100}) return K_WDBG;
      if (op[5:0] != 0 || op[7:6] == 2'b11) return K_BAD;
      if (op[15:8] == 8'h19) return K_RMEM;
      if (op[15:8] == 8'h18) return K_WMEM;
      if (op[15:8] == 8'h1D) return K_DUMP;
      if (op[15:8] == 8'h1C) return K_FILL;
      return K_BAD;
   endfunction

   assign mem_rdata = memval(mem_addr);
   assign reg_rdata = regval(reg_space, reg_idx);

   serial_dbg_cmd_decoder i_serial_dbg_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cpu_halted(cpu_halted),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(err_inj),
      .reg_en(reg_en), .reg_we(reg_we), .reg_space(reg_space), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_restart(cpu_restart), .pc_capture(pc_capture)
   );

   task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [15:0] op, input logic [31:0] addr,
                         input logic [31:0] data, input bit halted, input bit err);
      int k;
      bit hon, e_mem, e_reg, e_rwe, e_rst, e_sync, rdd, seen, got;
      logic [1:0] e_tag, e_sp, sz;
      logic [11:0] e_idx;
      logic [31:0] e_data, ea, s_addr, s_wdata;
      logic [1:0] s_size;
      logic s_we;
      string rq;
      int cyc;
      k = bkind(op);
      sz = op[7:6];
      hon = (k == K_GO) || (k == K_RREG) || (k == K_WREG) || (k == K_RCTL) || (k == K_WCTL);
      e_tag = 2'b00; e_data = '0; e_mem = 0; e_reg = 0; e_rwe = 0;
      e_rst = 0; e_sync = 0; e_sp = 0; e_idx = '0; ea = addr; rdd = 0;
      case (k)
         K_NOP, K_SYNC: rq = "R7";
         K_GO:          rq = "R6";
         K_RREG, K_WREG: rq = "R2";
         K_RMEM, K_WMEM: rq = "R4";
         K_DUMP, K_FILL: rq = "R5";
         K_RCTL, K_WCTL: rq = "R8";
         K_RDBG, K_WDBG: rq = "R9";
         default:       rq = "R10";
      endcase
      if (k == K_BAD) e_tag = 2'b11;
      else if (hon && !halted) begin e_tag = 2'b01; rq = "R3"; end
      else if (k >= K_RMEM && k <= K_FILL) begin
         rdd = (k == K_RMEM) || (k == K_DUMP);
         if (k == K_DUMP || k == K_FILL) ea = m_addr + nbytes(m_sz);
         if ((k == K_DUMP && !m_rd) || (k == K_FILL && !m_wr)) e_tag = 2'b11;
         else if ((sz == 2'b01 && ea[0]) || (sz == 2'b10 && ea[1:0] != 0)) begin
            e_tag = 2'b10; rq = "R11";
         end else begin
            e_mem = 1; m_addr = ea; m_sz = sz; m_rd = rdd; m_wr = !rdd;
            if (err) begin e_tag = 2'b10; rq = "R11"; end
            else if (rdd) e_data = fit(memval(ea), sz);
         end
      end else begin
         case (k)
            K_GO:   begin e_rst = 1; m_rd = 0; m_wr = 0; end
            K_SYNC: e_sync = 1;
            K_RREG, K_WREG: begin e_reg = 1; e_sp = 2'd0; e_idx = {8'd0, op[3:0]}; end
            K_RCTL, K_WCTL: begin e_reg = 1; e_sp = 2'd1; e_idx = addr[11:0]; end
            K_RDBG, K_WDBG: begin e_reg = 1; e_sp = 2'd2; e_idx = {7'd0, op[4:0]}; end
            default: ;
         endcase
         e_rwe = (k == K_WREG) || (k == K_WCTL) || (k == K_WDBG);
         if (e_reg && !e_rwe) e_data = regval(e_sp, e_idx);
      end

      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
      cpu_halted = halted; err_inj = err;
      #1;
      chk("R12", "cmd_ready idle", 64'(cmd_ready), 64'd1);
      chk(rq, "reg_en", 64'(reg_en), 64'(e_reg));
      if (e_reg) begin
         chk(rq, "reg_we", 64'(reg_we), 64'(e_rwe));
         chk(rq, "reg_space", 64'(reg_space), 64'(e_sp));
         chk(rq, "reg_idx", 64'(reg_idx), 64'(e_idx));
         if (e_rwe) chk(rq, "reg_wdata", 64'(reg_wdata), 64'(data));
      end
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R6", "cpu_restart", 64'(cpu_restart), 64'(e_rst));
      chk("R7", "pc_capture", 64'(pc_capture), 64'(e_sync));
      cyc = 1; seen = 0; got = 0;
      s_addr = '0; s_size = '0; s_we = 0; s_wdata = '0;
      for (int n = 0; n < 8 && !got; n++) begin
         if (rsp_valid) got = 1;
         else begin
            if (mem_req) begin
               seen = 1; s_addr = mem_addr; s_size = mem_size; s_we = mem_we; s_wdata = mem_wdata;
               chk("R12", "cmd_ready busy", 64'(cmd_ready), 64'd0);
               mem_ack = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            mem_ack = 1'b0;
            cyc++;
         end
      end
      chk(rq, "rsp_valid", 64'(got), 64'd1);
      chk(rq, "rsp_tag", 64'(rsp_tag), 64'(e_tag));
      chk(rq, "rsp_data", 64'(rsp_data), 64'(e_data));
      chk(rq, "latency", 64'(cyc), e_mem ? 64'd2 : 64'd1);
      chk(rq, "bus cycle", 64'(seen), 64'(e_mem));
      if (e_mem && seen) begin
         chk(rq, "mem_addr", 64'(s_addr), 64'(ea));
         chk(rq, "mem_size", 64'(s_size), 64'(sz));
         chk(rq, "mem_we", 64'(s_we), 64'(!rdd));
         chk(rq, "mem_wdata", 64'(s_wdata), rdd ? 64'd0 : 64'(fit(data, sz)));
      end
      err_inj = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] op;
      logic [31:0] ad;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
      chk("R1", "mem_req in reset", 64'(mem_req), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cmd_ready", 64'(cmd_ready), 64'd1);
      chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R1", "reg_en", 64'(reg_en), 64'd0);
      chk("R1", "strobes", 64'({cpu_restart, pc_capture}), 64'd0);

      // Directed corners
      do_cmd(16'h1D80, 32'h0, 32'h0, 1, 0);            // R5 continuation before setup
      do_cmd(16'h1980, 32'h0000_0100, 32'h0, 0, 0);    // R4 long read, CPU running
      do_cmd(16'h1D40, 32'h0, 32'h0, 0, 0);            // R5 addr 0x104
      do_cmd(16'h1D40, 32'h0, 32'h0, 0, 0);            // R5 addr 0x106
      do_cmd(16'h1D00, 32'h0, 32'h0, 0, 0);            // R5 addr 0x108
      do_cmd(16'h1C00, 32'h0, 32'h0, 1, 0);            // R5 write chain after read
      do_cmd(16'h1800, 32'h0000_0203, 32'hDEAD_BEEF, 1, 0); // R4 byte write
      do_cmd(16'h1C00, 32'h0, 32'h1234_5678, 1, 0);    // R5 fill 0x204
      do_cmd(16'h0C00, 32'h0, 32'h0, 0, 0);            // R3 restart while running
      do_cmd(16'h0C00, 32'h0, 32'h0, 1, 0);            // R6 restart
      do_cmd(16'h1C00, 32'h0, 32'h0, 1, 0);            // R6 block closed
      do_cmd(16'h1940, 32'h0000_0011, 32'h0, 1, 0);    // R11 odd word
      do_cmd(16'h1880, 32'h0000_0020, 32'h5, 1, 1);    // R11 bus error
      do_cmd(16'h2185, 32'h0, 32'h0, 0, 0);            // R3 core read running
      do_cmd(16'h208B, 32'h0, 32'hCAFE_0001, 1, 0);    // R2 write A3
      do_cmd(16'h2980, 32'h0000_0802, 32'h0, 1, 0);    // R8
      do_cmd(16'h2D8C, 32'h0, 32'h0, 0, 0);            // R9 any state
      do_cmd(16'h2DA0, 32'h0, 32'h0, 1, 0);            // R10 bad fixed field
      do_cmd(16'h19C0, 32'h0, 32'h0, 1, 0);            // R10 size 11
      do_cmd(16'h0001, 32'h0, 32'h0, 0, 0);            // R7
      do_cmd(16'h0000, 32'h0, 32'h0, 0, 0);            // R7

      for (int i = 0; i < 400; i++) begin
         logic [1:0] rs;
         rs = 2'($urandom % 4);
         case ($urandom % 10)
            0: op = {12'h218, 4'($urandom)};
            1: op = {12'h208, 4'($urandom)};
            2: op = {8'h19, rs, 6'd0};
            3: op = {8'h18, rs, 6'd0};
            4, 5: op = {8'h1D, (rs == 2'b11) ? 2'b10 : rs, 6'd0};
            6: op = {8'h1C, (rs == 2'b11) ? 2'b01 : rs, 6'd0};
            7: op = (rs == 0) ? 16'h0C00 : (rs == 1) ? 16'h0001 : (rs == 2) ? 16'h2980 : 16'h2880;
            8: op = {(rs[0] ? 8'h2D : 8'h2C), (rs[1] ? 3'($urandom) : 3'b100), 5'($urandom)};
            default: op = 16'($urandom);
         endcase
         ad = ($urandom % 8 == 0) ? 32'($urandom) : (32'($urandom) & 32'h0000_FFFC);
         do_cmd(op, ad, 32'($urandom), ($urandom % 4) != 0, ($urandom % 16) == 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule